// File: doc/BRIEF.md
# Extended Port Control Register Bank with Test FIFO

This block is the second register window of a parallel port. It holds three host-visible registers behind a small synchronous bus with a 3-bit offset. Offset 0 is a byte data port. Offset 1 is a general-purpose configuration byte. Offset 2 is the extended control register, which carries a 3-bit operating mode and reports the state of a two-byte FIFO.

In every mode except FIFO test, the data port is an ordinary byte register. In FIFO test mode the same offset becomes the FIFO's only access path: a host write pushes a byte and a host read pops one. The full and empty conditions are reported in the two low bits of the control register. Writing the control register with a new mode flushes the FIFO. The host reads status and data through the same bus it writes with. Read data is registered and stays on the output until the next read.

Top module: `xpar_ext_regs`

## Requirements
- R1: After reset, offset 2 reads 0x01 (mode 000 compatible, FIFO empty), offset 1 reads 0x00 and offset 0 reads 0x00.
- R2: Offsets 3 to 7 ignore writes and read as 0xFF.
- R3: A write to offset 2 stores bits 7:5 as the mode and bits 4:2 as plain bits. Bits 1:0 always show the FIFO state and are not writable: 01 empty, 10 full, 00 holding one byte.
- R4: A control write whose mode field differs from the current mode empties the FIFO and resets both pointers. A control write that keeps the mode leaves the FIFO contents and flags unchanged.
- R5: In FIFO test mode (mode 110), a write to offset 0 pushes the byte. The state field becomes 00 after one byte and 10 after two.
- R6: In FIFO test mode, reads of offset 0 pop bytes in the order they were written. The state field returns to 01 when the last byte is taken.
- R7: A push while the FIFO holds two bytes is dropped, and the stored bytes and their order are kept.
- R8: A pop while the FIFO is empty returns 0xFF and leaves the FIFO state unchanged.
- R9: In any mode other than 110, offset 0 is a plain byte register that reads back its last write, and the FIFO is not touched. That register keeps its value across time spent in test mode.
- R10: Offset 1 is a plain read/write byte.
- R11: A read and a write of offset 0 in the same cycle in test mode pop the old head and push the new byte. When full, the FIFO stays full. When empty, the read returns 0xFF and the byte is still stored.
- R12: rdata_o takes the addressed value at the clock edge where rd_en_i is high and holds it until the next read. A read in the same cycle as a write returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for one cycle |
| rd_en_i | input | 1 | Read strobe for one cycle |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |

## Verification
A push and a pop of the test FIFO can happen in the same cycle, because the bus allows a read and a write of offset 0 together. The bench drives both strobes at once with the FIFO empty, holding one byte and full. The scoreboard checks that the popped byte is the old head, or 0xFF when the FIFO was empty. Follow-up reads of the control register and of the data port then confirm the occupancy and that the new byte landed behind the old one.

// File: rtl/xpar_pkg.sv
package xpar_pkg;
  localparam int XP_ADDR_W = 3;
  localparam int XP_DATA_W = 8;

  localparam logic [XP_ADDR_W-1:0] OFS_DATA = 3'd0;
  localparam logic [XP_ADDR_W-1:0] OFS_CFGB = 3'd1;
  localparam logic [XP_ADDR_W-1:0] OFS_CTRL = 3'd2;

  // control register field positions
  localparam int MODE_LSB = 5;
  localparam int AUX_LSB  = 2;

  typedef enum logic [2:0] {
    MODE_COMPAT = 3'b000,
    MODE_BYTE   = 3'b001,
    MODE_PPFIFO = 3'b010,
    MODE_XFIFO  = 3'b011,
    MODE_EPP    = 3'b100,
    MODE_RSVD   = 3'b101,
    MODE_TEST   = 3'b110,
    MODE_CFG    = 3'b111
  } mode_e;
endpackage

// File: rtl/xpar_fifo.sv
module xpar_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              pop_ok, push_ok;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == FULL_CNT);
  assign pop_ok  = pop_i && !empty_o;
  // a pop in the same cycle frees the slot for a push
  assign push_ok = push_i && (!full_o || pop_ok);
  assign head_o  = mem_q[rd_ptr_q];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        mem_q[g] <= '0;
      else if (!flush_i && push_ok && wr_ptr_q == PTR_W'(g))
        mem_q[g] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_ok)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  a_r4_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (cnt_q == '0 && wr_ptr_q == '0 && rd_ptr_q == '0));
  a_r7_full_push_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && !pop_i && !flush_i) |=> (full_o && $stable(wr_ptr_q)));
  a_r8_empty_pop_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (empty_o && pop_i && !push_i && !flush_i) |=> (empty_o && $stable(rd_ptr_q)));
  a_r11_full_both_stays_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && push_i && pop_i && !flush_i) |=> full_o);
endmodule

// File: rtl/xpar_ctrl_reg.sv
module xpar_ctrl_reg
  import xpar_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [7:0] wdata_i,
  output mode_e      mode_o,
  output logic [2:0] aux_o,
  output logic       flush_o
);
  mode_e      mode_q;
  logic [2:0] aux_q;
  mode_e      new_mode;

  assign new_mode = mode_e'(wdata_i[MODE_LSB +: 3]);
  assign flush_o  = wr_i && (new_mode != mode_q);
  assign mode_o   = mode_q;
  assign aux_o    = aux_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_COMPAT;
      aux_q  <= '0;
    end else if (wr_i) begin
      mode_q <= new_mode;
      aux_q  <= wdata_i[AUX_LSB +: 3];
    end
  end

  a_r3_mode_replaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mode_o == mode_e'($past(wdata_i[MODE_LSB +: 3]))));
endmodule

// File: rtl/xpar_ext_regs.sv
module xpar_ext_regs
  import xpar_pkg::*;
#(
  parameter int FIFO_DEPTH = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic                 rd_en_i,
  input  logic [XP_ADDR_W-1:0] addr_i,
  input  logic [XP_DATA_W-1:0] wdata_i,
  output logic [XP_DATA_W-1:0] rdata_o
);
  mode_e                mode;
  logic [2:0]           aux;
  logic                 flush, test_mode;
  logic                 hit_data, hit_cfgb, hit_ctrl;
  logic                 fifo_empty, fifo_full;
  logic [XP_DATA_W-1:0] fifo_head;
  logic [XP_DATA_W-1:0] data_q, cfgb_q, rdata_q, rd_val, ctrl_val;

  assign hit_data  = (addr_i == OFS_DATA);
  assign hit_cfgb  = (addr_i == OFS_CFGB);
  assign hit_ctrl  = (addr_i == OFS_CTRL);
  assign test_mode = (mode == MODE_TEST);

  xpar_ctrl_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_en_i && hit_ctrl),
    .wdata_i (wdata_i),
    .mode_o  (mode),
    .aux_o   (aux),
    .flush_o (flush)
  );

  xpar_fifo #(.DATA_W(XP_DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (wr_en_i && hit_data && test_mode),
    .pop_i   (rd_en_i && hit_data && test_mode),
    .wdata_i (wdata_i),
    .head_o  (fifo_head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      cfgb_q <= '0;
    end else if (wr_en_i) begin
      if (hit_data && !test_mode) data_q <= wdata_i;
      if (hit_cfgb)               cfgb_q <= wdata_i;
    end
  end

  // status field: 01 empty, 10 full, 00 partial
  assign ctrl_val = {mode, aux, fifo_full, fifo_empty};

  always_comb begin
    unique case (1'b1)
      hit_data: rd_val = test_mode ? (fifo_empty ? '1 : fifo_head) : data_q;
      hit_cfgb: rd_val = cfgb_q;
      hit_ctrl: rd_val = ctrl_val;
      default:  rd_val = '1;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  a_r2_unmapped_reads_ones: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !hit_data && !hit_cfgb && !hit_ctrl) |=> (rdata_o == '1));
  a_r3_status_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({fifo_full, fifo_empty}));
  a_r12_read_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));
  a_r9_plain_reg_kept_in_test: assert property (@(posedge clk_i) disable iff (!rst_ni)
    test_mode |=> $stable(data_q));
endmodule

// File: tb/xpar_ext_regs_bench.sv
`timescale 1ns/1ps
module xpar_ext_regs_bench;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [2:0] addr_i = '0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;

  int n_chk = 0, n_fail = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       pend = 1'b0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  xpar_ext_regs u_xpar_ext_regs (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o)
  );

  always @(posedge clk) pend <= rd_en_i;

  // monitor: result of a read appears after the edge that sampled rd_en_i
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (rdata_o !== e) begin
        n_fail++;
        $display("FAIL %s: got 0x%02h expected 0x%02h", t, rdata_o, e);
      end
    end
  end

  task automatic op(input bit wr, input bit rd, input logic [2:0] a,
                    input logic [7:0] d, input logic [7:0] e, input string t);
    wr_en_i = wr; rd_en_i = rd; addr_i = a; wdata_i = d;
    if (rd) begin exp_q.push_back(e); tag_q.push_back(t); end
    @(negedge clk);
    wr_en_i = 1'b0; rd_en_i = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    op(1'b1, 1'b0, a, d, 8'h00, "");
  endtask
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    op(1'b0, 1'b1, a, 8'h00, e, t);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset values
    rd(3'd2, 8'h01, "R1 ctrl reset");
    rd(3'd1, 8'h00, "R1 cfgb reset");
    rd(3'd0, 8'h00, "R1 data reset");
    // R10 configuration byte
    wr(3'd1, 8'hA5);
    rd(3'd1, 8'hA5, "R10 cfgb readback");
    // R2 unmapped offsets
    wr(3'd5, 8'h12);
    rd(3'd5, 8'hFF, "R2 offset 5");
    rd(3'd7, 8'hFF, "R2 offset 7");
    rd(3'd1, 8'hA5, "R2 cfgb untouched");
    rd(3'd0, 8'h00, "R2 data untouched");
    // R9 plain data register in compatible mode
    wr(3'd0, 8'h3C);
    rd(3'd0, 8'h3C, "R9 plain data");
    rd(3'd2, 8'h01, "R9 fifo untouched");
    // R3 status bits not writable, aux bits stored
    wr(3'd2, 8'h1F);
    rd(3'd2, 8'h1D, "R3 ctrl write same mode");
    // enter test mode (110)
    wr(3'd2, 8'hC0);
    rd(3'd2, 8'hC1, "R4 test mode empty");
    // R5 push and flags
    wr(3'd0, 8'h11);
    rd(3'd2, 8'hC0, "R5 one byte partial");
    wr(3'd0, 8'h22);
    rd(3'd2, 8'hC2, "R5 two bytes full");
    // R7 push while full
    wr(3'd0, 8'h33);
    rd(3'd2, 8'hC2, "R7 still full");
    // R4 same-mode write keeps contents
    wr(3'd2, 8'hDC);
    rd(3'd2, 8'hDE, "R4 same mode keeps fifo");
    // R6 pop order and flags
    rd(3'd0, 8'h11, "R6 pop first");
    rd(3'd2, 8'hDC, "R6 partial after pop");
    rd(3'd0, 8'h22, "R7 R6 pop second, drop kept order");
    rd(3'd2, 8'hDD, "R6 empty again");
    // R8 pop while empty
    rd(3'd0, 8'hFF, "R8 empty pop");
    rd(3'd2, 8'hDD, "R8 state unchanged");
    // R11 simultaneous push/pop: empty, full, partial
    op(1'b1, 1'b1, 3'd0, 8'h44, 8'hFF, "R11 both on empty");
    rd(3'd2, 8'hDC, "R11 byte stored after empty both");
    wr(3'd0, 8'h55);
    op(1'b1, 1'b1, 3'd0, 8'h66, 8'h44, "R11 both on full");
    rd(3'd2, 8'hDE, "R11 stays full");
    rd(3'd0, 8'h55, "R11 order after full both a");
    rd(3'd0, 8'h66, "R11 order after full both b");
    rd(3'd0, 8'hFF, "R11 drained");
    wr(3'd0, 8'h77);
    op(1'b1, 1'b1, 3'd0, 8'h88, 8'h77, "R11 both on partial");
    rd(3'd0, 8'h88, "R11 new byte behind");
    // R4 mode change flushes
    wr(3'd0, 8'h99);
    rd(3'd2, 8'hDC, "R4 one byte before flush");
    wr(3'd2, 8'h20);
    rd(3'd2, 8'h21, "R4 mode change empties");
    rd(3'd0, 8'h3C, "R9 plain data kept across test mode");
    wr(3'd2, 8'hC0);
    rd(3'd0, 8'hFF, "R4 flushed data gone");
    wr(3'd0, 8'hAB);
    wr(3'd0, 8'hCD);
    rd(3'd0, 8'hAB, "R4 pointers reset a");
    rd(3'd0, 8'hCD, "R4 pointers reset b");
    // R12 read holds and same-cycle read/write returns old value
    wr(3'd2, 8'h00);
    op(1'b1, 1'b1, 3'd1, 8'h5A, 8'hA5, "R12 read before write");
    rd(3'd1, 8'h5A, "R12 write landed");
    repeat (3) @(negedge clk);
    n_chk++;
    if (rdata_o !== 8'h5A) begin
      n_fail++;
      $display("FAIL R12 hold: got 0x%02h expected 0x5a", rdata_o);
    end
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule